// File: doc/BRIEF.md
# UART Receive Buffer with Trigger Level and Character Timeout

This block buffers received characters for a 16550-style serial port. A deserializer hands it bytes one at a time with a valid strobe, or signals a line break with a separate strobe. Software pulls the bytes out through a read strobe. In buffered mode the block holds up to sixteen bytes in arrival order. It raises a trigger flag once a programmable fill level is reached. A character-time watchdog flags data that has waited too long without being read. In unbuffered mode a single holding register takes each byte.

Configuration arrives as a write strobe carrying the FIFO control byte. The current line format (data length, parity, stop bits) sets the length of one character. A bit-time tick paces the timeout counter. The read data port shows the oldest byte directly, so a byte is valid whenever data-ready is high and a read strobe pops it. A status-read strobe clears the sticky break and overrun flags.

Top module: `uart_rx_fifo`

## Requirements
- R1: The trigger level comes from cfg_data[7:6] of an accepted control write: 00 selects 1, 01 selects 4, 10 selects 8, 11 selects 14. In buffered mode trig_hit is high when data_ready is high and count is at least the level. In unbuffered mode trig_hit equals data_ready.
- R2: With cfg_data[0]=1 (buffered mode), bytes are kept in arrival order, up to 16. rd_data shows the oldest byte while data_ready is high. Each rd_strobe removes one byte, and count gives the number held.
- R3: A byte that arrives while 16 bytes are held, with no read in the same cycle, is discarded. The stored bytes are unchanged and overrun is set. If a read comes in the same cycle, the new byte is accepted.
- R4: In unbuffered mode (cfg_data[0]=0), a byte arriving while data_ready is high replaces the held byte and sets overrun, unless a read occurs in the same cycle. A read clears data_ready.
- R5: In buffered mode rd_data is 0x00 when nothing is held. A read that leaves the buffer empty clears data_ready and break_flag.
- R6: Any arrival restarts a timer of 4 character times, counted in bit_tick pulses, and so does a read that leaves bytes behind. If the timer runs out while bytes are held, timeout_pend rises at the last counted tick. Any rd_strobe clears timeout_pend.
- R7: One character lasts 1 + (5 + lcr_len) + lcr_par + (lcr_stop2 ? 2 : 1) bit times. The timeout is therefore 28 to 48 ticks.
- R8: rx_break stores a 0x00 byte and sets break_flag and data_ready. If rx_break and rx_valid are both high, only the 0x00 byte is stored.
- R9: A control write with cfg_data[1]=1, or one whose cfg_data[0] differs from the current mode, empties the buffer. It also clears data_ready, break_flag, the timer and timeout_pend, and discards a byte arriving in the same cycle. Overrun is not affected.
- R10: status_rd clears break_flag and overrun. A new break or overrun in the same cycle takes precedence.
- R11: After reset the block is in unbuffered mode with trigger level 1, count 0 and all flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_byte | input | 8 | Received character |
| rx_valid | input | 1 | rx_byte is valid this cycle |
| rx_break | input | 1 | Line break detected this cycle |
| cfg_wr | input | 1 | FIFO control write strobe |
| cfg_data | input | 8 | Control byte: [0] mode, [1] flush, [7:6] trigger |
| lcr_len | input | 2 | Data bits minus five |
| lcr_par | input | 1 | Parity bit present |
| lcr_stop2 | input | 1 | Two stop bits |
| bit_tick | input | 1 | One bit time elapsed |
| rd_strobe | input | 1 | Read and pop one byte |
| status_rd | input | 1 | Line status read, clears break and overrun |
| rd_data | output | 8 | Oldest byte (fall-through) |
| data_ready | output | 1 | A byte is available |
| break_flag | output | 1 | Break received |
| overrun | output | 1 | A byte was lost |
| count | output | 5 | Bytes held |
| trig_hit | output | 1 | Trigger level reached |
| timeout_pend | output | 1 | Character timeout pending |

## Verification
An arrival and a read can land in the same cycle. With the buffer full, the bench drives rx_valid and rd_strobe together. It then confirms that count stays at 16 and that the new byte comes out last, after the fifteen survivors. The second collision pairs a status read with an arrival that overruns the unbuffered holding register, and overrun must remain set afterwards. Flush against arrival is judged the same way: the buffer must be empty after a flush write that coincides with an arriving byte.

// File: rtl/uart_rxb_pkg.sv
`timescale 1ns/1ps
package uart_rxb_pkg;

  localparam int unsigned RXB_W = 8;
  localparam int unsigned RXB_MAX_CHAR = 12;

  // trigger select to fill level
  function automatic logic [4:0] trig_level(input logic [1:0] sel);
    case (sel)
      2'b00:   trig_level = 5'd1;
      2'b01:   trig_level = 5'd4;
      2'b10:   trig_level = 5'd8;
      default: trig_level = 5'd14;
    endcase
  endfunction

  // bit times in one character: start + data + parity + stop
  function automatic logic [3:0] char_bits(input logic [1:0] len,
                                           input logic par,
                                           input logic stop2);
    char_bits = 4'd6 + {2'b00, len} + {3'b000, par} + (stop2 ? 4'd2 : 4'd1);
  endfunction

endpackage

// File: rtl/rxb_store.sv
`timescale 1ns/1ps
module rxb_store #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic                         pop,
  input  logic                         flush,
  input  logic [W-1:0]                 din,
  output logic [W-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, wp_n, rp, rp_n;
  logic [CW-1:0] cnt, cnt_n;

  function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
    step_ptr = (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wp_n  = wp;
    rp_n  = rp;
    cnt_n = cnt;
    if (flush) begin
      wp_n  = '0;
      rp_n  = '0;
      cnt_n = '0;
    end else begin
      if (push) wp_n = step_ptr(wp);
      if (pop)  rp_n = step_ptr(rp);
      cnt_n = cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      wp  <= wp_n;
      rp  <= rp_n;
      cnt <= cnt_n;
    end
  end

  // storage entries, each with its own write enable
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
    logic we;
    assign we = push && !flush && (wp == PW'(gi));
    always_ff @(posedge clk) begin
      if (we) mem[gi] <= din;
    end
  end

  assign head  = mem[rp];
  assign count = cnt;

endmodule

// File: rtl/rxb_timeout.sv
`timescale 1ns/1ps
module rxb_timeout #(
  parameter int CHARS    = 4,
  parameter int MAX_CHAR = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       stop,
  input  logic       tick,
  input  logic [3:0] char_len,
  output logic       expire
);
  localparam int CW = $clog2(CHARS*MAX_CHAR + 1);

  logic          armed, armed_n;
  logic [CW-1:0] tcnt, tcnt_n;
  logic [CW-1:0] limit;
  logic          last;

  assign limit = CW'(CHARS) * CW'(char_len);
  assign last  = (tcnt == limit - 1'b1);

  always_comb begin
    armed_n = armed;
    tcnt_n  = tcnt;
    expire  = 1'b0;
    if (stop) begin
      armed_n = 1'b0;
      tcnt_n  = '0;
    end else if (restart) begin
      armed_n = 1'b1;
      tcnt_n  = '0;
    end else if (tick && armed) begin
      if (last) begin
        armed_n = 1'b0;
        tcnt_n  = '0;
        expire  = 1'b1;
      end else begin
        tcnt_n  = tcnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      tcnt  <= '0;
    end else begin
      armed <= armed_n;
      tcnt  <= tcnt_n;
    end
  end

endmodule

// File: rtl/uart_rx_fifo.sv
`timescale 1ns/1ps
module uart_rx_fifo
  import uart_rxb_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int TO_CHARS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [RXB_W-1:0]           rx_byte,
  input  logic                       rx_valid,
  input  logic                       rx_break,
  input  logic                       cfg_wr,
  input  logic [7:0]                 cfg_data,
  input  logic [1:0]                 lcr_len,
  input  logic                       lcr_par,
  input  logic                       lcr_stop2,
  input  logic                       bit_tick,
  input  logic                       rd_strobe,
  input  logic                       status_rd,
  output logic [RXB_W-1:0]           rd_data,
  output logic                       data_ready,
  output logic                       break_flag,
  output logic                       overrun,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       trig_hit,
  output logic                       timeout_pend
);
  localparam int CNT_W = $clog2(DEPTH+1);

  // configuration and flag registers
  logic             fifo_en, fifo_en_n;
  logic [1:0]       trig_sel, trig_sel_n;
  logic [RXB_W-1:0] hold, hold_n;
  logic             hold_dr, hold_dr_n;
  logic             brk, brk_n;
  logic             ovr, ovr_n;
  logic             pend, pend_n;

  // datapath
  logic             flush, arrive, push_req, push_ok, drop, rd_fifo, restart, expire;
  logic [RXB_W-1:0] arr_byte, head;
  logic [CNT_W-1:0] cnt, cnt_after;

  assign flush    = cfg_wr && (cfg_data[1] || (cfg_data[0] != fifo_en));
  assign arrive   = (rx_valid || rx_break) && !flush;
  assign arr_byte = rx_break ? '0 : rx_byte;
  assign rd_fifo  = rd_strobe && fifo_en && !flush && (cnt != '0);
  assign push_req = arrive && fifo_en;
  assign push_ok  = push_req && ((cnt < CNT_W'(DEPTH)) || rd_fifo);
  assign drop     = push_req && !push_ok;
  assign cnt_after = cnt + CNT_W'(push_ok) - CNT_W'(rd_fifo);
  assign restart  = push_req || (rd_fifo && (cnt_after != '0));

  rxb_store #(.DEPTH(DEPTH), .W(RXB_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push_ok),
    .pop   (rd_fifo),
    .flush (flush),
    .din   (arr_byte),
    .head  (head),
    .count (cnt)
  );

  rxb_timeout #(.CHARS(TO_CHARS), .MAX_CHAR(RXB_MAX_CHAR)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .stop     (flush),
    .tick     (bit_tick),
    .char_len (char_bits(lcr_len, lcr_par, lcr_stop2)),
    .expire   (expire)
  );

  always_comb begin
    fifo_en_n  = fifo_en;
    trig_sel_n = trig_sel;
    hold_n     = hold;
    hold_dr_n  = hold_dr;
    brk_n      = brk;
    ovr_n      = ovr;
    pend_n     = pend;

    if (cfg_wr) begin
      fifo_en_n  = cfg_data[0];
      trig_sel_n = cfg_data[7:6];
    end

    // single holding register used in unbuffered mode
    if (flush) begin
      hold_dr_n = 1'b0;
    end else if (arrive && !fifo_en) begin
      hold_n    = arr_byte;
      hold_dr_n = 1'b1;
    end else if (rd_strobe && !fifo_en) begin
      hold_dr_n = 1'b0;
    end

    // break flag: set has priority over every clear
    if (arrive && rx_break) begin
      brk_n = 1'b1;
    end else if (flush || status_rd ||
                 (rd_strobe && (fifo_en ? (cnt_after == '0) : 1'b1))) begin
      brk_n = 1'b0;
    end

    // overrun: lost FIFO byte or overwritten holding register
    if (drop || (!fifo_en && arrive && !rx_break && hold_dr && !rd_strobe)) begin
      ovr_n = 1'b1;
    end else if (status_rd) begin
      ovr_n = 1'b0;
    end

    // timeout pending
    if (flush || rd_strobe) begin
      pend_n = 1'b0;
    end else if (expire && (cnt != '0)) begin
      pend_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_en  <= 1'b0;
      trig_sel <= 2'b00;
      hold     <= '0;
      hold_dr  <= 1'b0;
      brk      <= 1'b0;
      ovr      <= 1'b0;
      pend     <= 1'b0;
    end else begin
      fifo_en  <= fifo_en_n;
      trig_sel <= trig_sel_n;
      hold     <= hold_n;
      hold_dr  <= hold_dr_n;
      brk      <= brk_n;
      ovr      <= ovr_n;
      pend     <= pend_n;
    end
  end

  assign data_ready   = fifo_en ? (cnt != '0) : hold_dr;
  assign rd_data      = fifo_en ? ((cnt != '0) ? head : '0) : hold;
  assign trig_hit     = data_ready &&
                        (!fifo_en || (cnt >= CNT_W'(trig_level(trig_sel))));
  assign break_flag   = brk;
  assign overrun      = ovr;
  assign count        = cnt;
  assign timeout_pend = pend;

endmodule

// File: rtl/uart_rx_fifo_chk.sv
`timescale 1ns/1ps
module uart_rx_fifo_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       rx_valid,
  input logic                       rx_break,
  input logic                       cfg_wr,
  input logic [7:0]                 cfg_data,
  input logic                       rd_strobe,
  input logic                       fifo_en,
  input logic [$clog2(DEPTH+1)-1:0] count,
  input logic                       data_ready,
  input logic                       break_flag,
  input logic                       overrun,
  input logic                       timeout_pend,
  input logic                       trig_hit
);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= DEPTH); // R2

  AST_POP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en && rd_strobe && (count != 0) && !rx_valid && !rx_break && !cfg_wr
    |=> count == $past(count) - 1'b1); // R2

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en && (count == DEPTH) && rx_valid && !rd_strobe && !cfg_wr
    |=> (count == DEPTH) && overrun); // R3

  AST_RD_CLR_TO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> !timeout_pend); // R6

  AST_BRK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rx_break && !cfg_wr |=> data_ready && break_flag); // R8

  AST_FLUSH_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && cfg_data[1]
    |=> (count == 0) && !data_ready && !break_flag && !timeout_pend); // R9

  AST_TRIG_DR: assert property (@(posedge clk) disable iff (!rst_n)
    trig_hit |-> data_ready); // R1

endmodule

bind uart_rx_fifo uart_rx_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_valid     (rx_valid),
  .rx_break     (rx_break),
  .cfg_wr       (cfg_wr),
  .cfg_data     (cfg_data),
  .rd_strobe    (rd_strobe),
  .fifo_en      (fifo_en),
  .count        (count),
  .data_ready   (data_ready),
  .break_flag   (break_flag),
  .overrun      (overrun),
  .timeout_pend (timeout_pend),
  .trig_hit     (trig_hit)
);

// File: tb/sim_uart_rx_fifo.sv
`timescale 1ns/1ps
module sim_uart_rx_fifo;

  logic       clk;
  logic       rst_n;
  logic [7:0] rx_byte;
  logic       rx_valid, rx_break, cfg_wr;
  logic [7:0] cfg_data;
  logic [1:0] lcr_len;
  logic       lcr_par, lcr_stop2, bit_tick, rd_strobe, status_rd;
  logic [7:0] rd_data;
  logic       data_ready, break_flag, overrun, trig_hit, timeout_pend;
  logic [4:0] count;

  int checks = 0;
  int fails  = 0;

  uart_rx_fifo u0 (
    .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .rx_break(rx_break), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .lcr_len(lcr_len), .lcr_par(lcr_par), .lcr_stop2(lcr_stop2),
    .bit_tick(bit_tick), .rd_strobe(rd_strobe), .status_rd(status_rd),
    .rd_data(rd_data), .data_ready(data_ready), .break_flag(break_flag),
    .overrun(overrun), .count(count), .trig_hit(trig_hit),
    .timeout_pend(timeout_pend)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fcr(input logic [7:0] v);
    cfg_wr = 1'b1; cfg_data = v;
    step();
    cfg_wr = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    rx_valid = 1'b1; rx_byte = b;
    step();
    rx_valid = 1'b0;
  endtask

  task automatic pop_chk(input string req, input logic [7:0] exp);
    check(req, rd_data, exp);
    rd_strobe = 1'b1;
    step();
    rd_strobe = 1'b0;
  endtask

  task automatic stat_rd();
    status_rd = 1'b1;
    step();
    status_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1'b1;
      step();
    end
    bit_tick = 1'b0;
  endtask

  task automatic t_reset();
    check("R11 count", count, 0);
    check("R11 data_ready", data_ready, 0);
    check("R11 flags", {break_flag, overrun, timeout_pend, trig_hit}, 0);
  endtask

  task automatic t_unbuffered();
    push(8'hA5);
    check("R4 dr", data_ready, 1);
    check("R4 data", rd_data, 8'hA5);
    check("R1 trig unbuffered", trig_hit, 1);
    push(8'h3C);
    check("R4 replace", rd_data, 8'h3C);
    check("R4 overrun", overrun, 1);
    pop_chk("R4 read", 8'h3C);
    check("R4 dr cleared", data_ready, 0);
    stat_rd();
    check("R10 overrun cleared", overrun, 0);
    // status read racing a fresh overrun
    push(8'h11);
    rx_valid = 1'b1; rx_byte = 8'h22; status_rd = 1'b1;
    step();
    rx_valid = 1'b0; status_rd = 1'b0;
    check("R10 set wins", overrun, 1);
    stat_rd();
    pop_chk("R4 read2", 8'h22);
  endtask

  task automatic t_order();
    fcr(8'h01);
    check("R9 mode change empties", count, 0);
    push(8'h5A);
    check("R1 level1", trig_hit, 1);
    pop_chk("R2 single", 8'h5A);
    fcr(8'h43);
    for (int i = 1; i <= 4; i++) begin
      push(8'(i));
      check("R1 level4", trig_hit, (i >= 4) ? 1 : 0);
    end
    check("R2 count", count, 4);
    for (int i = 1; i <= 4; i++) pop_chk("R2 order", 8'(i));
    check("R5 dr after empty", data_ready, 0);
    check("R5 empty data", rd_data, 0);
    pop_chk("R5 empty read", 8'h00);
    check("R5 count stays", count, 0);
  endtask

  task automatic t_overflow();
    fcr(8'hC3);
    for (int i = 0; i < 16; i++) begin
      push(8'h10 + 8'(i));
      if (i == 12 || i == 13) check("R1 level14", trig_hit, (i == 13) ? 1 : 0);
    end
    check("R3 full", count, 16);
    check("R3 no overrun yet", overrun, 0);
    push(8'hEE);
    check("R3 count kept", count, 16);
    check("R3 overrun", overrun, 1);
    stat_rd();
    check("R10 clear", overrun, 0);
    // arrival and read in the same cycle while full
    check("R3 head", rd_data, 8'h10);
    rx_valid = 1'b1; rx_byte = 8'h77; rd_strobe = 1'b1;
    step();
    rx_valid = 1'b0; rd_strobe = 1'b0;
    check("R3 simultaneous count", count, 16);
    check("R3 simultaneous no overrun", overrun, 0);
    for (int i = 1; i < 16; i++) pop_chk("R3 kept", 8'h10 + 8'(i));
    pop_chk("R3 accepted last", 8'h77);
    check("R3 drained", count, 0);
  endtask

  task automatic t_break();
    fcr(8'h03);
    push(8'h55);
    rx_valid = 1'b1; rx_byte = 8'h99; rx_break = 1'b1;
    step();
    rx_valid = 1'b0; rx_break = 1'b0;
    check("R8 one entry", count, 2);
    check("R8 break", break_flag, 1);
    pop_chk("R8 first", 8'h55);
    check("R5 break held", break_flag, 1);
    pop_chk("R8 null", 8'h00);
    check("R5 break cleared", break_flag, 0);
    check("R5 dr cleared", data_ready, 0);
  endtask

  task automatic t_timeout();
    fcr(8'h03);
    lcr_len = 2'd3; lcr_par = 1'b1; lcr_stop2 = 1'b1;
    push(8'h01);
    ticks(47);
    check("R7 48 ticks early", timeout_pend, 0);
    ticks(1);
    check("R6 expire", timeout_pend, 1);
    pop_chk("R6 data", 8'h01);
    check("R6 read clears", timeout_pend, 0);
    lcr_len = 2'd0; lcr_par = 1'b0; lcr_stop2 = 1'b0;
    push(8'h02);
    push(8'h03);
    ticks(27);
    check("R7 28 ticks early", timeout_pend, 0);
    pop_chk("R6 restart read", 8'h02);
    ticks(27);
    check("R6 restarted", timeout_pend, 0);
    ticks(1);
    check("R6 expire2", timeout_pend, 1);
    pop_chk("R6 data2", 8'h03);
    push(8'h04);
    pop_chk("R6 data3", 8'h04);
    ticks(60);
    check("R6 empty no pend", timeout_pend, 0);
  endtask

  task automatic t_flush();
    fcr(8'h00);
    push(8'h01);
    push(8'h02);
    check("R9 pre overrun", overrun, 1);
    fcr(8'h01);
    check("R9 mode switch dr", data_ready, 0);
    push(8'hA1);
    push(8'hA2);
    rx_break = 1'b1;
    step();
    rx_break = 1'b0;
    fcr(8'h03);
    check("R9 flush count", count, 0);
    check("R9 flush break", break_flag, 0);
    check("R9 overrun kept", overrun, 1);
    cfg_wr = 1'b1; cfg_data = 8'h03; rx_valid = 1'b1; rx_byte = 8'hB0;
    step();
    cfg_wr = 1'b0; rx_valid = 1'b0;
    check("R9 flush wins", count, 0);
    push(8'hC0);
    fcr(8'h00);
    check("R9 to unbuffered", {count, data_ready}, 0);
    stat_rd();
    check("R10 final clear", overrun, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx_byte = '0; rx_valid = 1'b0; rx_break = 1'b0;
    cfg_wr = 1'b0; cfg_data = '0; lcr_len = 2'd3; lcr_par = 1'b0;
    lcr_stop2 = 1'b0; bit_tick = 1'b0; rd_strobe = 1'b0; status_rd = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_unbuffered();
    t_order();
    t_overflow();
    t_break();
    t_timeout();
    t_flush();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule